// File: doc/BRIEF.md
# Frame and Multiframe Alignment Defect Monitor

This block sits behind a frame aligner on an optical transport receive path and judges the quality of alignment once per frame. On each frame strobe it takes a flag telling whether the frame alignment word matched, and the received multiframe counter byte. From these it builds a frame-level and a multiframe-level out-of-alignment defect through consecutive-frame persistence filters. A second stage then promotes each defect into a loss defect when it has stood for a set number of pulses of a free-running millisecond tick.

The multiframe byte is expected to count up by one per frame. The block keeps its own reference copy and compares each received byte against that copy plus one. While the frame-level defect is raised, the multiframe logic is frozen. A frame counter reports how many strobes have passed since the last change of either out-of-alignment defect.

Top module: `frm_align_mon`

## Requirements
- R1: The frame defect `oof` rises after SET_FRAMES (default 5) consecutive strobes with `fas_ok` low. A strobe with `fas_ok` high before that point restarts the count.
- R2: A raised `oof` falls after CLR_FRAMES (default 2) consecutive strobes with `fas_ok` high. A strobe with `fas_ok` low restarts the count.
- R3: The first strobe judged after reset only adopts `mf_byte` as the reference. After that, a byte is correct when it equals the reference plus one, modulo 256. While `oom` is high, every judged byte becomes the new reference. While `oom` is low, a correct byte becomes the reference and a wrong byte advances the reference by one.
- R4: `oom` rises after SET_FRAMES consecutive wrong multiframe bytes. It falls after CLR_FRAMES consecutive correct ones.
- R5: `lof` rises once `oof` has been high continuously through LOSS_TICKS (default 3) pulses of `ms_tick`. Any drop of `oof` restarts that count.
- R6: `lof` falls once `oof` has been low continuously through LOSS_TICKS tick pulses. Any return of `oof` restarts that count.
- R7: `lom` follows `oom` under the same tick rules as R5 and R6.
- R8: A strobe that arrives while `oof` is high does not touch the multiframe logic. `oom`, its run count and the reference all hold their values.
- R9: `frm_cnt` is zero after reset. It is set to zero by a strobe that changes `oof` or `oom`. Every other strobe adds one, and the count saturates at its all-ones value.
- R10: After reset, `oof`, `lof`, `oom` and `lom` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_stb | input | 1 | One-cycle pulse per received frame |
| fas_ok | input | 1 | Frame alignment word matched in this frame |
| mf_byte | input | 8 | Received multiframe counter byte |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| oof | output | 1 | Out-of-frame defect |
| lof | output | 1 | Loss-of-frame defect |
| oom | output | 1 | Out-of-multiframe defect |
| lom | output | 1 | Loss-of-multiframe defect |
| frm_cnt | output | CNT_W | Strobes since the last out-of-alignment state change |

## Verification
Some properties are checked on every cycle by the assertions:
- A defect changes only on a strobe that carries the matching flag.
- A loss defect changes only on a tick, and only toward the level of its source.
- `oom` is frozen while `oof` is high.
- The counter reads zero after any transition.

The exact run lengths, the restart of counts by an interrupting frame or level drop, the wrap of the multiframe reference at 255 and the counter saturation are shown only by the bench. The bench sweeps every run length from one to seven against a model it computes from these rules.

// File: rtl/frm_align_pkg.sv
package frm_align_pkg;
  localparam int MF_W = 8;
  typedef logic [MF_W-1:0] mf_byte_t;
endpackage

// File: rtl/persist_filt.sv
module persist_filt #(
  parameter int SET_N = 5,
  parameter int CLR_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic good,
  output logic def,
  output logic flip
);
  localparam int MAXN = (SET_N > CLR_N) ? SET_N : CLR_N;
  localparam int CW   = $clog2(MAXN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          def_q, def_d;
  logic [CW-1:0] last;
  logic          hit;

  always_comb begin
    last  = def_q ? CW'(CLR_N - 1) : CW'(SET_N - 1);
    hit   = def_q ? good : !good;
    cnt_d = cnt_q;
    def_d = def_q;
    flip  = 1'b0;
    if (en) begin
      if (hit) begin
        if (cnt_q == last) begin
          cnt_d = '0;
          def_d = !def_q;
          flip  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      def_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      def_q <= def_d;
    end
  end

  assign def = def_q;

  // R1 / R4: a defect is raised only by a judged bad frame
  a_r1_set_on_bad_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(def_q) |-> $past(en && !good));
  // R2 / R4: a defect is cleared only by a judged good frame
  a_r2_clear_on_good_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(def_q) |-> $past(en && good));
endmodule

// File: rtl/ms_integ.sv
module ms_integ #(
  parameter int TH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic tick,
  output logic q
);
  localparam int CW = $clog2(TH + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          q_q, q_d;

  always_comb begin
    cnt_d = cnt_q;
    q_d   = q_q;
    if (lvl == q_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == CW'(TH - 1)) begin
        cnt_d = '0;
        q_d   = lvl;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  assign q = q_q;

  // R5 / R7: the loss level rises only on a tick while its source is high
  a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_q) |-> $past(tick && lvl));
  // R6 / R7: the loss level falls only on a tick while its source is low
  a_r6_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q_q) |-> $past(tick && !lvl));
endmodule

// File: rtl/mf_check.sv
module mf_check
  import frm_align_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  mf_byte_t mf_in,
  input  logic     in_oom,
  output logic     judge,
  output logic     mf_good
);
  mf_byte_t ref_q, ref_d;
  logic     seeded_q, seeded_d;

  always_comb begin
    mf_good  = (mf_in == mf_byte_t'(ref_q + 1'b1));
    judge    = en && seeded_q;
    ref_d    = ref_q;
    seeded_d = seeded_q;
    if (en) begin
      if (!seeded_q) begin
        seeded_d = 1'b1;
        ref_d    = mf_in;
      end else if (mf_good || in_oom) begin
        ref_d = mf_in;
      end else begin
        ref_d = ref_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= '0;
      seeded_q <= 1'b0;
    end else if (en) begin
      ref_q    <= ref_d;
      seeded_q <= seeded_d;
    end
  end

  // R3: once seeded, the checker stays seeded
  a_r3_seed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seeded_q |=> seeded_q);
endmodule

// File: rtl/frm_align_mon.sv
module frm_align_mon
  import frm_align_pkg::*;
#(
  parameter int SET_FRAMES = 5,
  parameter int CLR_FRAMES = 2,
  parameter int LOSS_TICKS = 3,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_stb,
  input  logic             fas_ok,
  input  logic [MF_W-1:0]  mf_byte,
  input  logic             ms_tick,
  output logic             oof,
  output logic             lof,
  output logic             oom,
  output logic             lom,
  output logic [CNT_W-1:0] frm_cnt
);
  logic oof_flip, oom_flip;
  logic mf_en, mf_judge, mf_good;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  persist_filt #(.SET_N(SET_FRAMES), .CLR_N(CLR_FRAMES)) u_oof (
    .clk(clk), .rst_n(rst_n), .en(frm_stb), .good(fas_ok),
    .def(oof), .flip(oof_flip));

  assign mf_en = frm_stb && !oof;

  mf_check u_mf (
    .clk(clk), .rst_n(rst_n), .en(mf_en), .mf_in(mf_byte), .in_oom(oom),
    .judge(mf_judge), .mf_good(mf_good));

  persist_filt #(.SET_N(SET_FRAMES), .CLR_N(CLR_FRAMES)) u_oom (
    .clk(clk), .rst_n(rst_n), .en(mf_judge), .good(mf_good),
    .def(oom), .flip(oom_flip));

  ms_integ #(.TH(LOSS_TICKS)) u_lof (
    .clk(clk), .rst_n(rst_n), .lvl(oof), .tick(ms_tick), .q(lof));

  ms_integ #(.TH(LOSS_TICKS)) u_lom (
    .clk(clk), .rst_n(rst_n), .lvl(oom), .tick(ms_tick), .q(lom));

  always_comb begin
    cnt_d = cnt_q;
    if (oof_flip || oom_flip) begin
      cnt_d = '0;
    end else if (cnt_q != {CNT_W{1'b1}}) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (frm_stb) begin
      cnt_q <= cnt_d;
    end
  end

  assign frm_cnt = cnt_q;

  // R8: multiframe state holds while out of frame
  a_r8_mf_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    oof |=> $stable(oom));
  // R9: any alignment state change leaves the counter at zero
  a_r9_cnt_zero_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(oof) || !$stable(oom)) |-> (frm_cnt == '0));
endmodule

// File: tb/frm_align_mon_tb.sv
module frm_align_mon_tb_top;
  localparam int SETN = 5;
  localparam int CLRN = 2;
  localparam int TH   = 3;
  localparam int CW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_stb = 1'b0;
  logic fas_ok = 1'b0;
  logic [7:0] mf_byte = 8'h00;
  logic ms_tick = 1'b0;
  logic oof, lof, oom, lom;
  logic [CW-1:0] frm_cnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench model state
  logic m_oof = 0, m_oom = 0, m_lof = 0, m_lom = 0, m_seed = 0;
  int   m_fc = 0, m_mc = 0, m_lc = 0, m_mlc = 0, m_cnt = 0;
  logic [7:0] m_ref = 8'h00;

  always #10 clk = ~clk;

  frm_align_mon #(.SET_FRAMES(SETN), .CLR_FRAMES(CLRN),
                  .LOSS_TICKS(TH), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .fas_ok(fas_ok),
    .mf_byte(mf_byte), .ms_tick(ms_tick), .oof(oof), .lof(lof),
    .oom(oom), .lom(lom), .frm_cnt(frm_cnt));

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, "/R1R2"}, "oof", oof, m_oof);
    chk({tag, "/R4"}, "oom", oom, m_oom);
    chk({tag, "/R5R6"}, "lof", lof, m_lof);
    chk({tag, "/R7"}, "lom", lom, m_lom);
    chk({tag, "/R9"}, "frm_cnt", frm_cnt, m_cnt);
  endtask

  task automatic frame(input string tag, input logic ok, input logic [7:0] b);
    logic o, mo, good, hit, ff, fm;
    int need;
    o = m_oof; ff = 0; fm = 0;
    hit = o ? ok : !ok;
    need = o ? CLRN : SETN;
    if (hit) begin
      if (m_fc == need - 1) begin m_oof = !o; m_fc = 0; ff = 1; end
      else m_fc++;
    end else m_fc = 0;
    if (!o) begin // R8: multiframe logic untouched while out of frame
      if (!m_seed) begin m_seed = 1; m_ref = b; end
      else begin
        mo = m_oom;
        good = (b == m_ref + 8'd1);
        hit = mo ? good : !good;
        need = mo ? CLRN : SETN;
        if (hit) begin
          if (m_mc == need - 1) begin m_oom = !mo; m_mc = 0; fm = 1; end
          else m_mc++;
        end else m_mc = 0;
        if (good || mo) m_ref = b; else m_ref = m_ref + 8'd1;
      end
    end
    if (ff || fm) m_cnt = 0;
    else if (m_cnt != (1 << CW) - 1) m_cnt++;
    if (m_oof == m_lof) m_lc = 0;
    if (m_oom == m_lom) m_mlc = 0;
    @(negedge clk);
    fas_ok = ok; mf_byte = b; frm_stb = 1'b1;
    @(negedge clk);
    frm_stb = 1'b0;
    @(negedge clk);
    compare(tag);
  endtask

  // send a frame whose multiframe byte is correct (junk while out of frame)
  task automatic good_mf(input string tag, input logic ok);
    frame(tag, ok, m_oof ? 8'h5A : m_ref + 8'd1);
  endtask

  task automatic tick(input string tag);
    if (m_oof != m_lof) begin
      if (m_lc == TH - 1) begin m_lof = m_oof; m_lc = 0; end else m_lc++;
    end else m_lc = 0;
    if (m_oom != m_lom) begin
      if (m_mlc == TH - 1) begin m_lom = m_oom; m_mlc = 0; end else m_mlc++;
    end else m_mlc = 0;
    @(negedge clk);
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R10");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R10");

    // R3: seeding and steady in-frame operation
    for (int i = 0; i < 4; i++) good_mf("R3", 1'b1);

    // R1/R2 sweep: bad alignment runs of every length 1..7, then recovery
    for (int k = 1; k <= 7; k++) begin
      for (int i = 0; i < k; i++) good_mf("R1", 1'b0);
      good_mf("R2", 1'b1);
      good_mf("R2", 1'b1);
      good_mf("R2", 1'b1);
    end
    // R2: interrupted clearing run
    for (int i = 0; i < SETN; i++) good_mf("R1", 1'b0);
    good_mf("R2", 1'b1);
    good_mf("R2", 1'b0);
    good_mf("R2", 1'b1);
    good_mf("R2", 1'b1);

    // R3/R4 sweep: wrong multiframe runs of length 1..7, then correct bytes
    for (int j = 1; j <= 7; j++) begin
      for (int i = 0; i < j; i++) frame("R4", 1'b1, m_ref + 8'h40);
      for (int i = 0; i < 3; i++) good_mf("R4", 1'b1);
    end

    // R3: wrap of the reference through 255 while in OOM, then in multiframe
    for (int i = 0; i < SETN; i++) frame("R4", 1'b1, 8'h10);
    frame("R3", 1'b1, 8'hFC);
    frame("R3", 1'b1, 8'hFD);
    frame("R3", 1'b1, 8'hFE);
    frame("R3", 1'b1, 8'hFF);
    frame("R3", 1'b1, 8'h00);
    frame("R3", 1'b1, 8'h01);

    // R8: junk multiframe bytes while out of frame leave oom and reference alone
    for (int i = 0; i < SETN; i++) good_mf("R8", 1'b0);
    for (int i = 0; i < 6; i++) frame("R8", 1'b0, 8'hC3);
    good_mf("R8", 1'b1);
    good_mf("R8", 1'b1);
    for (int i = 0; i < 3; i++) good_mf("R8", 1'b1);

    // R5/R6: loss of frame after the tick threshold, and its release
    for (int i = 0; i < SETN; i++) good_mf("R5", 1'b0);
    for (int n = 0; n < TH + 1; n++) tick("R5");
    for (int i = 0; i < CLRN; i++) good_mf("R6", 1'b1);
    for (int n = 0; n < TH + 1; n++) tick("R6");
    // R5: interrupted integration restarts
    for (int i = 0; i < SETN; i++) good_mf("R5", 1'b0);
    tick("R5"); tick("R5");
    for (int i = 0; i < CLRN; i++) good_mf("R5", 1'b1);
    tick("R5");
    for (int i = 0; i < SETN; i++) good_mf("R5", 1'b0);
    tick("R5"); tick("R5"); tick("R5");
    // R6: interrupted release restarts
    for (int i = 0; i < CLRN; i++) good_mf("R6", 1'b1);
    tick("R6"); tick("R6");
    for (int i = 0; i < SETN; i++) good_mf("R6", 1'b0);
    for (int i = 0; i < CLRN; i++) good_mf("R6", 1'b1);
    for (int n = 0; n < TH + 1; n++) tick("R6");

    // R7: loss of multiframe set and release
    for (int i = 0; i < SETN; i++) frame("R7", 1'b1, m_ref + 8'h22);
    for (int n = 0; n < TH + 1; n++) tick("R7");
    for (int i = 0; i < CLRN + 1; i++) good_mf("R7", 1'b1);
    for (int n = 0; n < TH + 1; n++) tick("R7");

    // R9: counter saturation
    for (int i = 0; i < 20; i++) good_mf("R9", 1'b1);
    chk("R9", "saturated frm_cnt", frm_cnt, (1 << CW) - 1);

    finish_run();
  end
endmodule